// File: doc/BRIEF.md
# I2C Bus Timing Generator

This block sets the timing of the SCL clock edges and the SDA transitions for an I2C master. Four clock-count inputs set the timing. The first is the whole bit period. The second is the part of that period during which SCL is held low. The third is a shared setup/hold time used around START, repeated START and STOP edges. The fourth is the lead time between an SDA change and the next SCL rise. The SCL high time is not programmed on its own: it is whatever remains of the bit period after the low time.

A byte engine requests one phase at a time: START, repeated START, one data bit, or STOP. The block drives the two open-drain lines through that phase. It can only pull a line low or release it. It pulses a done strobe when the phase ends, and it returns the SDA level it sampled at the end of a data bit's high time. While SCL is released, each count waits for the SCL line to actually read high, so a target that holds SCL low stretches the clock.

A bus-recovery mode hands SCL to software and releases SDA. A four-bit monitor reports the raw and driven levels of both lines.

Top module: `i2c_bus_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, both lines are released (`scl_drive_low`=0, `sda_drive_low`=0), `busy`=0 and `phase_done`=0.
- R2: A data-bit phase (`req_kind`=2) keeps SCL pulled low for `cfg_low` cycles. It then releases SCL for `cfg_period`-`cfg_low` cycles. `phase_done` rises with SCL pulled low again, `cfg_period` cycles after the accepting edge.
- R3: In a data-bit phase, SDA takes the level `req_bit` only while SCL is low. The change happens `cfg_data_setup` cycles before SCL is released. If the level does not change, SDA does not move at all.
- R4: At the end of a data-bit phase, `rx_bit` holds the SDA line level sampled on the last clock of the SCL high time.
- R5: A START (`req_kind`=0) pulls SDA low at once while SCL stays released. `cfg_edge_setup` cycles later it pulls SCL low, and `phase_done` pulses.
- R6: A repeated START (`req_kind`=1) runs in three steps: SDA released with SCL low for `cfg_low` cycles, then SCL released for `cfg_edge_setup` cycles, then SDA pulled low for `cfg_edge_setup` cycles. SCL is then pulled low with `phase_done`.
- R7: A STOP (`req_kind`=3) runs in three steps: SDA low with SCL low for `cfg_low` cycles, then SCL released for `cfg_edge_setup` cycles, then SDA released for `cfg_edge_setup` cycles. It ends with both lines released and `phase_done` high.
- R8: While the block releases SCL, its count advances only on cycles in which the SCL line reads high. Each cycle in which another device holds SCL low delays the phase end by one cycle.
- R9: `phase_done` lasts exactly one cycle. A request is accepted only while `busy` is low. A request raised during a phase has no effect, and the lines hold their levels between phases.
- R10: With `norm_en` low, SCL is pulled low exactly when `scl_release` is 0 and SDA is released. Requests are ignored and `phase_done` stays low.
- R11: `bus_mon` bit 0 is the SCL line level, bit 1 the SCL level the block drives (1 = released), bit 2 the SDA line level, and bit 3 the SDA level the block drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| norm_en | input | 1 | 1 = normal operation, 0 = bus-recovery mode |
| scl_release | input | 1 | SCL level in recovery mode (0 pulls SCL low) |
| cfg_period | input | CNT_W | Bit period in clocks |
| cfg_low | input | CNT_W | SCL low time in clocks |
| cfg_edge_setup | input | CNT_W | Setup/hold time around START, repeated START and STOP |
| cfg_data_setup | input | CNT_W | Clocks from an SDA change to the SCL release |
| req_valid | input | 1 | Phase request |
| req_kind | input | 2 | 0 START, 1 repeated START, 2 data bit, 3 STOP |
| req_bit | input | 1 | SDA level for a data bit |
| busy | output | 1 | A phase is in progress |
| phase_done | output | 1 | One-cycle strobe at the end of a phase |
| rx_bit | output | 1 | SDA level sampled in the last data bit |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| bus_mon | output | 4 | Raw and driven line levels |

## Verification
The bench builds the block with 8-bit counters. This keeps bit periods short enough to visit every legal split of a 6 to 10 clock period: every low time, every data-setup lead inside it, and two edge-setup values. Each split runs a complete START, data, repeated START and STOP sequence. Every SDA edge, SCL edge and done cycle is compared against timings computed arithmetically. Separate runs cover clock stretching, requests raised in mid-phase, the recovery mode and the monitor bits.

// File: rtl/i2c_btg_pkg.sv
package i2c_btg_pkg;

    // Phase request codes; the byte engine depends on these values.
    typedef enum logic [1:0] {
        PH_START   = 2'd0,
        PH_RESTART = 2'd1,
        PH_BIT     = 2'd2,
        PH_STOP    = 2'd3
    } phase_e;

    // Timed segments that make up the phases.
    typedef enum logic [3:0] {
        SG_READY,
        SG_BIT_LOW,
        SG_BIT_SET,
        SG_BIT_HIGH,
        SG_RS_LOW,
        SG_RS_HIGH,
        SG_ST_HOLD,
        SG_SP_LOW,
        SG_SP_HIGH,
        SG_SP_FREE
    } seg_e;

    // Levels the block intends for the lines (1 = released).
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    localparam lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/i2c_btg_cnt.sv
module i2c_btg_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    assign zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && !zero) begin
            cnt_q <= cnt_q - W'(1);
        end
    end
endmodule

// File: rtl/i2c_btg_seq.sv
module i2c_btg_seq
    import i2c_btg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_bit,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_edge_setup,
    input  logic [CNT_W-1:0] cfg_data_setup,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_tick,
    output lines_t           lines,
    output logic             busy,
    output logic             done,
    output logic             rx_bit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seg_e   seg_q, seg_d;
    lines_t lvl_q, lvl_d;
    logic   bit_q, bit_d;
    logic   done_q, done_d;
    logic   rx_q, rx_d;
    logic   seg_end;
    logic [CNT_W-1:0] hi_raw, pre_raw;

    // A programmed count of N gives a segment of N cycles (zero acts as one).
    function automatic logic [CNT_W-1:0] to_load(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - ONE;
    endfunction

    assign hi_raw  = (cfg_period > cfg_low) ? cfg_period - cfg_low : '0;
    assign pre_raw = (cfg_low > cfg_data_setup) ? cfg_low - cfg_data_setup : '0;

    // Any segment with SCL released waits for the line to read high.
    assign cnt_tick = !lvl_q.scl || scl_in;
    assign seg_end  = (seg_q != SG_READY) && cnt_zero && cnt_tick;

    always_comb begin
        seg_d    = seg_q;
        lvl_d    = lvl_q;
        bit_d    = bit_q;
        rx_d     = rx_q;
        done_d   = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (seg_q)
            SG_READY: begin
                if (req_valid) begin
                    cnt_load = 1'b1;
                    unique case (phase_e'(req_kind))
                        PH_START: begin
                            seg_d   = SG_ST_HOLD;
                            lvl_d   = '{scl: 1'b1, sda: 1'b0};
                            cnt_val = to_load(cfg_edge_setup);
                        end
                        PH_RESTART: begin
                            seg_d   = SG_RS_LOW;
                            lvl_d   = '{scl: 1'b0, sda: 1'b1};
                            cnt_val = to_load(cfg_low);
                        end
                        PH_BIT: begin
                            seg_d     = SG_BIT_LOW;
                            lvl_d.scl = 1'b0;
                            bit_d     = req_bit;
                            cnt_val   = to_load(pre_raw);
                        end
                        PH_STOP: begin
                            seg_d   = SG_SP_LOW;
                            lvl_d   = '{scl: 1'b0, sda: 1'b0};
                            cnt_val = to_load(cfg_low);
                        end
                        default: seg_d = SG_READY;
                    endcase
                end
            end
            SG_BIT_LOW: if (seg_end) begin
                seg_d     = SG_BIT_SET;
                lvl_d.sda = bit_q;
                cnt_load  = 1'b1;
                cnt_val   = to_load(cfg_data_setup);
            end
            SG_BIT_SET: if (seg_end) begin
                seg_d     = SG_BIT_HIGH;
                lvl_d.scl = 1'b1;
                cnt_load  = 1'b1;
                cnt_val   = to_load(hi_raw);
            end
            SG_BIT_HIGH: if (seg_end) begin
                seg_d     = SG_READY;
                lvl_d.scl = 1'b0;
                rx_d      = sda_in;
                done_d    = 1'b1;
            end
            SG_RS_LOW: if (seg_end) begin
                seg_d     = SG_RS_HIGH;
                lvl_d.scl = 1'b1;
                cnt_load  = 1'b1;
                cnt_val   = to_load(cfg_edge_setup);
            end
            SG_RS_HIGH: if (seg_end) begin
                seg_d     = SG_ST_HOLD;
                lvl_d.sda = 1'b0;
                cnt_load  = 1'b1;
                cnt_val   = to_load(cfg_edge_setup);
            end
            SG_ST_HOLD: if (seg_end) begin
                seg_d     = SG_READY;
                lvl_d.scl = 1'b0;
                done_d    = 1'b1;
            end
            SG_SP_LOW: if (seg_end) begin
                seg_d     = SG_SP_HIGH;
                lvl_d.scl = 1'b1;
                cnt_load  = 1'b1;
                cnt_val   = to_load(cfg_edge_setup);
            end
            SG_SP_HIGH: if (seg_end) begin
                seg_d     = SG_SP_FREE;
                lvl_d.sda = 1'b1;
                cnt_load  = 1'b1;
                cnt_val   = to_load(cfg_edge_setup);
            end
            SG_SP_FREE: if (seg_end) begin
                seg_d  = SG_READY;
                done_d = 1'b1;
            end
            default: seg_d = SG_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= SG_READY;
            lvl_q  <= LINES_IDLE;
            bit_q  <= 1'b1;
            done_q <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            seg_q  <= seg_d;
            lvl_q  <= lvl_d;
            bit_q  <= bit_d;
            done_q <= done_d;
            rx_q   <= rx_d;
        end
    end

    assign lines  = lvl_q;
    assign busy   = (seg_q != SG_READY);
    assign done   = done_q;
    assign rx_bit = rx_q;
endmodule

// File: rtl/i2c_btg_pads.sv
module i2c_btg_pads
    import i2c_btg_pkg::*;
(
    input  logic       norm_en,
    input  logic       scl_release,
    input  lines_t     lines,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic [3:0] bus_mon
);
    lines_t drv;

    // Recovery mode hands SCL to software and lets SDA float.
    always_comb begin
        if (norm_en) begin
            drv = lines;
        end else begin
            drv = '{scl: scl_release, sda: 1'b1};
        end
    end

    assign scl_drive_low = !drv.scl;
    assign sda_drive_low = !drv.sda;
    assign bus_mon       = {drv.sda, sda_in, drv.scl, scl_in};
endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer
    import i2c_btg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             norm_en,
    input  logic             scl_release,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_edge_setup,
    input  logic [CNT_W-1:0] cfg_data_setup,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_bit,
    output logic             busy,
    output logic             phase_done,
    output logic             rx_bit,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic [3:0]       bus_mon
);
    logic             seq_rst;
    logic             cnt_load, cnt_tick, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    lines_t           lines;

    assign seq_rst = rst || !norm_en;

    i2c_btg_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (seq_rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .tick     (cnt_tick),
        .zero     (cnt_zero)
    );

    i2c_btg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk            (clk),
        .rst            (seq_rst),
        .req_valid      (req_valid && norm_en),
        .req_kind       (req_kind),
        .req_bit        (req_bit),
        .cfg_period     (cfg_period),
        .cfg_low        (cfg_low),
        .cfg_edge_setup (cfg_edge_setup),
        .cfg_data_setup (cfg_data_setup),
        .scl_in         (scl_in),
        .sda_in         (sda_in),
        .cnt_zero       (cnt_zero),
        .cnt_load       (cnt_load),
        .cnt_val        (cnt_val),
        .cnt_tick       (cnt_tick),
        .lines          (lines),
        .busy           (busy),
        .done           (phase_done),
        .rx_bit         (rx_bit)
    );

    i2c_btg_pads u_pads (
        .norm_en       (norm_en),
        .scl_release   (scl_release),
        .lines         (lines),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .bus_mon       (bus_mon)
    );
endmodule

// File: rtl/i2c_bus_timer_chk.sv
module i2c_bus_timer_chk (
    input logic clk,
    input logic rst,
    input logic norm_en,
    input logic req_valid,
    input logic busy,
    input logic phase_done,
    input logic scl_in,
    input logic scl_drive_low,
    input logic sda_drive_low
);
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        phase_done |-> !busy); // R9

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (norm_en && req_valid && !busy) |=> busy); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (norm_en && $past(norm_en) && !busy && !$past(busy))
        |-> ($stable(scl_drive_low) && $stable(sda_drive_low))); // R9

    AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (rst)
        (norm_en && busy && !scl_drive_low && !scl_in)
        |=> (!phase_done && !scl_drive_low)); // R8

    AST_DONE_LINES: assert property (@(posedge clk) disable iff (rst)
        phase_done |-> (scl_drive_low || !sda_drive_low)); // R7

    AST_RECOVERY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!norm_en && !$past(norm_en)) |-> (!busy && !phase_done && !sda_drive_low)); // R10
endmodule

bind i2c_bus_timer i2c_bus_timer_chk u_chk (.*);

// File: tb/test_i2c_bus_timer.sv
module test_i2c_bus_timer;
    localparam int CW = 8;
    localparam logic [1:0] K_START = 2'd0, K_RESTART = 2'd1, K_BIT = 2'd2, K_STOP = 2'd3;

    logic clk = 1'b0;
    logic rst, norm_en, scl_release, req_valid, req_bit;
    logic [1:0] req_kind;
    logic [CW-1:0] cfg_period, cfg_low, cfg_edge_setup, cfg_data_setup;
    logic busy, phase_done, rx_bit, scl_in, sda_in, scl_drive_low, sda_drive_low;
    logic [3:0] bus_mon;
    logic ext_hold = 1'b0;
    logic slave_low = 1'b0;
    int n_chk = 0, n_fail = 0;
    int c_per, c_low, c_es, c_ds;

    always #5 clk = ~clk;

    assign scl_in = !scl_drive_low && !ext_hold;
    assign sda_in = !sda_drive_low && !slave_low;

    i2c_bus_timer #(.CNT_W(CW)) i_i2c_bus_timer (
        .clk(clk), .rst(rst), .norm_en(norm_en), .scl_release(scl_release),
        .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_edge_setup(cfg_edge_setup), .cfg_data_setup(cfg_data_setup),
        .req_valid(req_valid), .req_kind(req_kind), .req_bit(req_bit),
        .busy(busy), .phase_done(phase_done), .rx_bit(rx_bit),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .bus_mon(bus_mon)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int p, input int l, input int e, input int d);
        c_per = p; c_low = l; c_es = e; c_ds = d;
        cfg_period = CW'(p); cfg_low = CW'(l);
        cfg_edge_setup = CW'(e); cfg_data_setup = CW'(d);
    endtask

    // Runs one phase from a negedge and compares every edge time with the arithmetic model.
    task automatic run_phase(input logic [1:0] k, input logic b, input int hold, input int poke);
        logic sda0, scl0, p, was_low, rxv;
        int e_done, e_sda, e_sclr, e_scld;
        int t_done, t_sda, t_sclr, t_scld;
        sda0 = sda_drive_low; scl0 = scl_drive_low; p = !sda0;
        was_low = scl0; rxv = 1'b0;
        t_done = -1; t_sda = -1; t_sclr = -1; t_scld = -1;
        case (k)
            K_START:   begin e_done = c_es + 1; e_sda = 1; e_sclr = -1; e_scld = c_es + 1; end
            K_RESTART: begin e_done = c_low + 2*c_es + 1; e_sda = (p == 1'b0) ? 1 : c_low + c_es + 1;
                             e_sclr = c_low + 1; e_scld = e_done; end
            K_BIT:     begin e_done = c_per + 1 + hold; e_sda = (b != p) ? c_low - c_ds + 1 : -1;
                             e_sclr = c_low + 1; e_scld = e_done; end
            default:   begin e_done = c_low + 2*c_es + 1; e_sda = (p == 1'b1) ? 1 : c_low + c_es + 1;
                             e_sclr = c_low + 1; e_scld = -1; end
        endcase
        req_valid = 1'b1; req_kind = k; req_bit = b;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 1; n <= 1000; n++) begin
            if (t_sda < 0 && sda_drive_low != sda0) t_sda = n;
            if (!scl_drive_low && was_low && t_sclr < 0) t_sclr = n;
            if (scl_drive_low && t_scld < 0 && (!scl0 || t_sclr > 0)) t_scld = n;
            if (scl_drive_low) was_low = 1'b1;
            if (t_sclr > 0) ext_hold = (n < t_sclr + hold);
            if (n == poke) begin req_valid = 1'b1; req_kind = K_STOP; end
            else if (n == poke + 1) req_valid = 1'b0;
            if (phase_done) begin t_done = n; rxv = rx_bit; break; end
            @(negedge clk);
        end
        ext_hold = 1'b0;
        req_valid = 1'b0;
        case (k)
            K_START: begin
                chk("R5 START done cycle", t_done, e_done);
                chk("R5 START SDA fall", t_sda, e_sda);
                chk("R5 START SCL fall", t_scld, e_scld);
            end
            K_RESTART: begin
                chk("R6 RESTART done cycle", t_done, e_done);
                chk("R6 RESTART first SDA change", t_sda, e_sda);
                chk("R6 RESTART SCL rise", t_sclr, e_sclr);
                chk("R6 RESTART SCL fall", t_scld, e_scld);
                chk("R6 RESTART SDA low at end", sda_drive_low, 1);
            end
            K_BIT: begin
                chk("R2 BIT done cycle", t_done, e_done);
                chk("R2 BIT SCL rise", t_sclr, e_sclr);
                chk("R2 BIT SCL fall", t_scld, e_scld);
                chk("R3 BIT SDA change", t_sda, e_sda);
                chk("R3 BIT SDA level", sda_drive_low, int'(!b));
                chk("R4 BIT sampled bit", rxv, int'(b && !slave_low));
            end
            default: begin
                chk("R7 STOP done cycle", t_done, e_done);
                chk("R7 STOP first SDA change", t_sda, e_sda);
                chk("R7 STOP SCL rise", t_sclr, e_sclr);
                chk("R7 STOP SCL released", scl_drive_low, 0);
                chk("R7 STOP SDA released", sda_drive_low, 0);
            end
        endcase
        @(negedge clk);
        chk("R9 done one cycle", phase_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int idx;
        rst = 1'b1; norm_en = 1'b1; scl_release = 1'b1;
        req_valid = 1'b0; req_kind = K_START; req_bit = 1'b0;
        set_cfg(8, 4, 2, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset SCL released", scl_drive_low, 0);
        chk("R1 reset SDA released", sda_drive_low, 0);
        chk("R1 reset busy", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset SCL", scl_drive_low, 0);
        chk("R1 after reset SDA", sda_drive_low, 0);
        chk("R1 after reset busy", busy, 0);
        chk("R1 after reset done", phase_done, 0);

        // Sweep every legal low/data-setup split of small periods.
        idx = 0;
        for (int per = 6; per <= 10; per++)
            for (int lo = 3; lo <= per - 2; lo++)
                for (int ds = 1; ds < lo; ds++)
                    for (int es = 1; es <= 3; es += 2) begin
                        set_cfg(per, lo, es, ds);
                        run_phase(K_START, 1'b0, 0, 0);
                        slave_low = idx[0];
                        run_phase(K_BIT, 1'b1, 0, 0);
                        slave_low = 1'b0;
                        run_phase(K_BIT, 1'b0, 0, 0);
                        run_phase(K_BIT, 1'b0, 0, 0);
                        run_phase(K_RESTART, 1'b0, 0, 0);
                        run_phase(K_BIT, 1'b1, 0, 0);
                        run_phase(K_RESTART, 1'b0, 0, 0);
                        run_phase(K_BIT, idx[1], 0, 0);
                        run_phase(K_STOP, 1'b0, 0, 0);
                        idx++;
                    end

        // R8: clock stretching delays the end of the high time.
        set_cfg(8, 4, 2, 1);
        run_phase(K_START, 1'b0, 0, 0);
        run_phase(K_BIT, 1'b1, 3, 0);
        run_phase(K_BIT, 1'b0, 7, 0);

        // R9: a request raised mid-phase is ignored.
        run_phase(K_BIT, 1'b1, 0, 2);
        repeat (5) begin
            chk("R9 no extra done", phase_done, 0);
            @(negedge clk);
        end
        chk("R9 ignored STOP left SCL low", scl_drive_low, 1);
        chk("R9 ignored STOP not busy", busy, 0);
        chk("R11 monitor with both lines driven/high", bus_mon, 4'b1100);
        run_phase(K_STOP, 1'b0, 0, 0);

        // R11: monitor bits in idle.
        chk("R11 monitor idle", bus_mon, 4'b1111);
        ext_hold = 1'b1;
        #1 chk("R11 monitor SCL held", bus_mon, 4'b1110);
        slave_low = 1'b1;
        #1 chk("R11 monitor both held", bus_mon, 4'b1010);
        ext_hold = 1'b0; slave_low = 1'b0;

        // R10: recovery mode.
        @(negedge clk);
        norm_en = 1'b0; scl_release = 1'b0;
        @(negedge clk);
        chk("R10 recovery SCL pulled", scl_drive_low, 1);
        chk("R10 recovery SDA released", sda_drive_low, 0);
        chk("R11 recovery monitor", bus_mon, 4'b1100);
        scl_release = 1'b1;
        @(negedge clk);
        chk("R10 recovery SCL released", scl_drive_low, 0);
        req_valid = 1'b1; req_kind = K_START;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 6; n++) begin
            chk("R10 recovery no done", phase_done, 0);
            chk("R10 recovery SDA untouched", sda_drive_low, 0);
            @(negedge clk);
        end
        norm_en = 1'b1;
        @(negedge clk);
        chk("R10 back to normal idle", busy, 0);
        run_phase(K_START, 1'b0, 0, 0);
        run_phase(K_STOP, 1'b0, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule